// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits in a synchronous clock domain and runs single-byte read and write cycles on an external asynchronous static RAM of 128K bytes. On the memory side it drives the address, an active-low and an active-high chip select, an active-low output enable and an active-low write enable. The bidirectional data bus is split into a data-in port, a data-out port and a driver enable, which a pad ring joins into one tristate bus.

On the user side a command is offered with `req` together with a read/write select, an address and write data. The command is taken in the cycle where both `req` and `ready` are high. A read returns its byte on `rd_data` with a single-cycle `rd_valid` strobe. Every phase length is derived at elaboration from nanosecond minimums and the clock period, rounded up to whole cycles. Between commands the memory is held deselected, which puts it in standby.

Top module: `asram_ctrl`

## Requirements
- R1: While no command is in progress, `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0, so the memory sits in standby and neither side drives the bus.
- R2: `ready` is 1 exactly when no command is in progress. A command is accepted at the rising edge where `req` and `ready` are both 1. A `req` raised while `ready` is 0 is ignored.
- R3: Address and write data are latched at acceptance. `mem_addr` holds the accepted address for the whole command, whatever `req_addr` does meanwhile.
- R4: A read (`req_we`=0) starts in the cycle after acceptance with `mem_cs_n`=0, `mem_cs`=1, `mem_oe_n`=0 and `mem_we_n`=1. This lasts NRD = max(ceil(RD_CYC_NS/CLK_NS), ceil(RD_ACC_NS/CLK_NS), ceil(OE_ACC_NS/CLK_NS)) cycles, which is 6 with the default parameters.
- R5: Read data is sampled from `mem_dq_in` at the clock edge that ends the read phase. It appears on `rd_data` in the next cycle, together with a one-cycle `rd_valid` pulse, and equals the byte last written to that address.
- R6: After the read phase the memory is deselected for NHZ = ceil(RD_REL_NS/CLK_NS) cycles (default 2) before `ready` returns. The `rd_valid` cycle is the first of these.
- R7: A write (`req_we`=1) starts in the cycle after acceptance with `mem_cs_n`=0, `mem_cs`=1, `mem_we_n`=0 and `mem_oe_n`=1. This lasts NWP = max(ceil(WR_PULSE_NS/CLK_NS), ceil(WR_ADDR_NS/CLK_NS), ceil(WR_DSETUP_NS/CLK_NS)+1) cycles (default 5).
- R8: `mem_dq_oe` is 0 in the first write-pulse cycle, 1 in the remaining pulse cycles and in the first cycle after `mem_we_n` rises, and 0 at all other times. `mem_dq_out` equals the latched write data whenever `mem_dq_oe` is 1. `mem_oe_n` is 1 whenever `mem_dq_oe` is 1.
- R9: After the write pulse the memory is deselected with `mem_we_n`=1 for NWR = max(1, ceil(WR_CYC_NS/CLK_NS) - NWP) cycles (default 1) before `ready` returns. `rd_valid` never pulses for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Command request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (17) | Byte address |
| req_wdata | input | DATA_W (8) | Write data |
| ready | output | 1 | Controller idle, command can be accepted |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | DATA_W | Data from the memory |

## Verification
The bench compares every pin in every cycle of each command against the phase lengths it computes itself. An off-by-one phase counter therefore shows up as a shortened or lengthened strobe, or as an early or late `ready`. A design that enabled its drivers in the same cycle as the write enable falls, or held them past the first recovery cycle, fails the driver-window check. Sampling the memory one edge late or early returns garbage instead of the stored byte. To show that acceptance and latching are idle-only, the bench raises a conflicting request and scrambles the address and data inputs while a command is in progress. A design that reacted would move `mem_addr` or start an extra command. Reads at the lowest and highest addresses, and all-zero and all-one data, catch truncated or mis-routed bits.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_RD   = 3'd1,
      PH_RDHZ = 3'd2,
      PH_WR   = 3'd3,
      PH_WREC = 3'd4
   } phase_t;

   // whole cycles needed to cover ns at a clock period of clk_ns
   function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int unsigned umax(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int unsigned N_RD  = 6,
   parameter int unsigned N_HZ  = 2,
   parameter int unsigned N_WP  = 5,
   parameter int unsigned N_WR  = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req,
   input  logic   req_we,
   output phase_t st_q,
   output phase_t st_d,
   output logic   accept,
   output logic   cap_en
);

   localparam int unsigned N_MAX = umax(umax(N_RD, N_HZ), umax(N_WP, N_WR));
   localparam int unsigned CNT_W = $clog2(N_MAX + 1);

   localparam logic [CNT_W-1:0] LD_RD = CNT_W'(N_RD - 1);
   localparam logic [CNT_W-1:0] LD_HZ = CNT_W'(N_HZ - 1);
   localparam logic [CNT_W-1:0] LD_WP = CNT_W'(N_WP - 1);
   localparam logic [CNT_W-1:0] LD_WR = CNT_W'(N_WR - 1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             last;

   assign last = (cnt_q == '0);

   always_comb begin
      st_d   = st_q;
      cnt_d  = last ? '0 : cnt_q - 1'b1;
      accept = 1'b0;
      cap_en = 1'b0;
      unique case (st_q)
         PH_IDLE: begin
            cnt_d = '0;
            if (req) begin
               accept = 1'b1;
               if (req_we) begin
                  st_d  = PH_WR;
                  cnt_d = LD_WP;
               end else begin
                  st_d  = PH_RD;
                  cnt_d = LD_RD;
               end
            end
         end
         PH_RD: if (last) begin
            cap_en = 1'b1;
            st_d   = PH_RDHZ;
            cnt_d  = LD_HZ;
         end
         PH_RDHZ: if (last) st_d = PH_IDLE;
         PH_WR: if (last) begin
            st_d  = PH_WREC;
            cnt_d = LD_WR;
         end
         PH_WREC: if (last) st_d = PH_IDLE;
         default: begin
            st_d  = PH_IDLE;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   // R5: a capture only closes a read phase and always hands over to release
   a_r5_cap_to_release: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> (st_q == PH_RDHZ));

   // R2: a command never starts except from idle
   a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == PH_RD || st_q == PH_WR) && !$stable(st_q)) |-> ($past(st_q) == PH_IDLE));

endmodule

// File: rtl/asram_pins.sv
module asram_pins
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_t            st_q,
   input  phase_t            st_d,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_cs,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe
);

   logic sel_d, oe_d, we_d, drv_d;

   always_comb begin
      sel_d = (st_d == PH_RD) || (st_d == PH_WR);
      oe_d  = (st_d == PH_RD);
      we_d  = (st_d == PH_WR);
      // drive from the second pulse cycle through the first cycle after release
      drv_d = (st_q == PH_WR) && ((st_d == PH_WR) || (st_d == PH_WREC));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_cs_n  <= 1'b1;
         mem_cs    <= 1'b0;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
      end else begin
         mem_cs_n  <= !sel_d;
         mem_cs    <= sel_d;
         mem_oe_n  <= !oe_d;
         mem_we_n  <= !we_d;
         mem_dq_oe <= drv_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
      end else if (accept) begin
         mem_addr   <= req_addr;
         mem_dq_out <= req_wdata;
      end
   end

   // R8: never drive while the memory may be driving
   a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R8: drivers come on only after write enable has already been low
   a_r8_drive_after_we: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> (!mem_we_n && !$past(mem_we_n)));

   // R7: a write strobe is always a selected, output-disabled cycle
   a_r7_write_encoding: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs_n && mem_cs && mem_oe_n));

   // R4: output enable only with the chip selected and no write
   a_r4_read_encoding: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_cs_n && mem_cs && mem_we_n));

endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
   parameter int unsigned DATA_W  = 8,
   parameter bit          RD_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= cap_en;
         if (cap_en) cap_q <= mem_dq_in;
      end
   end

   generate
      if (RD_HOLD) begin : g_hold
         assign rd_data = cap_q;
      end else begin : g_gate
         assign rd_data = rd_valid ? cap_q : '0;
      end
   endgenerate

   // R5: the valid strobe is a single-cycle pulse
   a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W       = 17,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned CLK_NS       = 10,
   parameter int unsigned RD_CYC_NS    = 55,
   parameter int unsigned RD_ACC_NS    = 55,
   parameter int unsigned OE_ACC_NS    = 30,
   parameter int unsigned RD_REL_NS    = 20,
   parameter int unsigned WR_CYC_NS    = 55,
   parameter int unsigned WR_PULSE_NS  = 40,
   parameter int unsigned WR_ADDR_NS   = 50,
   parameter int unsigned WR_DSETUP_NS = 25,
   parameter bit          RD_HOLD      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_cs,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int unsigned N_RD = umax(1, umax(umax(ns2cyc(RD_CYC_NS, CLK_NS),
                                                    ns2cyc(RD_ACC_NS, CLK_NS)),
                                               ns2cyc(OE_ACC_NS, CLK_NS)));
   localparam int unsigned N_HZ = umax(1, ns2cyc(RD_REL_NS, CLK_NS));
   localparam int unsigned N_WP = umax(umax(ns2cyc(WR_PULSE_NS, CLK_NS),
                                            ns2cyc(WR_ADDR_NS, CLK_NS)),
                                       ns2cyc(WR_DSETUP_NS, CLK_NS) + 1);
   localparam int unsigned N_WC = ns2cyc(WR_CYC_NS, CLK_NS);
   localparam int unsigned N_WR = (N_WC > N_WP + 1) ? (N_WC - N_WP) : 1;

   generate
      if (CLK_NS == 0) begin : g_bad_clk
         $error("asram_ctrl: CLK_NS must be nonzero");
      end
      if (ADDR_W == 0 || DATA_W == 0) begin : g_bad_width
         $error("asram_ctrl: ADDR_W and DATA_W must be nonzero");
      end
      if (N_WP < 2) begin : g_bad_wp
         $error("asram_ctrl: write pulse must span at least two cycles");
      end
   endgenerate

   phase_t st_q, st_d;
   logic   accept, cap_en;

   assign ready = (st_q == PH_IDLE);

   asram_seq #(
      .N_RD (N_RD),
      .N_HZ (N_HZ),
      .N_WP (N_WP),
      .N_WR (N_WR)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req),
      .req_we (req_we),
      .st_q   (st_q),
      .st_d   (st_d),
      .accept (accept),
      .cap_en (cap_en)
   );

   asram_pins #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .st_q       (st_q),
      .st_d       (st_d),
      .accept     (accept),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .mem_addr   (mem_addr),
      .mem_cs_n   (mem_cs_n),
      .mem_cs     (mem_cs),
      .mem_oe_n   (mem_oe_n),
      .mem_we_n   (mem_we_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe)
   );

   asram_rdcap #(
      .DATA_W  (DATA_W),
      .RD_HOLD (RD_HOLD)
   ) u_rdcap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cap_en),
      .mem_dq_in (mem_dq_in),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   // R1: idle means standby on every memory control pin
   a_r1_standby: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe));

   // R3: the address cannot move while a command is in progress
   a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !$past(ready)) |-> $stable(mem_addr));

   // R9: a write never produces read data
   a_r9_no_valid_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n || mem_dq_oe) |-> !rd_valid);

endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

   localparam int TCLK = 10;
   localparam int AW = 17;
   localparam int DW = 8;

   function automatic int cdiv(int ns);
      return (ns + TCLK - 1) / TCLK;
   endfunction
   function automatic int mx(int a, int b);
      return (a > b) ? a : b;
   endfunction

   localparam int NRD = mx(mx(cdiv(55), cdiv(55)), cdiv(30));
   localparam int NHZ = cdiv(20);
   localparam int NWP = mx(mx(cdiv(40), cdiv(50)), cdiv(25) + 1);
   localparam int NWR = mx(1, cdiv(55) - NWP);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          ready, rd_valid;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] mem_addr;
   logic          mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in;

   always #(TCLK/2) clk = ~clk;

   asram_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
      .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;

   // ---------------- behavioural memory ----------------
   logic [DW-1:0] mem [int];
   logic [DW-1:0] shadow [int];

   function automatic logic [DW-1:0] fill(int a);
      return 8'(a) ^ 8'(a >> 8) ^ 8'h3C;
   endfunction

   always @* begin
      if (!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n)
         mem_dq_in = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : fill(int'(mem_addr));
      else
         mem_dq_in = 8'hE7;
   end

   logic          p_sel = 1'b0, p_we_n = 1'b1, p_doe = 1'b0;
   logic [AW-1:0] p_addr = '0;
   logic [DW-1:0] p_dq = '0;
   always @(negedge clk) begin
      if (p_sel && !p_we_n && mem_we_n)
         mem[int'(p_addr)] = p_doe ? p_dq : 8'hXX;
      p_sel  = !mem_cs_n && mem_cs;
      p_we_n = mem_we_n;
      p_doe  = mem_dq_oe;
      p_addr = mem_addr;
      p_dq   = mem_dq_out;
   end

   // ---------------- checking helpers ----------------
   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, expv, $time);
      end
   endtask

   // order {cs_n, cs, oe_n, we_n, dq_oe}
   task automatic chk_pins(string tag, logic [4:0] expv);
      logic [4:0] act;
      act = {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe};
      chk(act === expv, tag, 32'(act), 32'(expv));
   endtask

   task automatic accept_cmd(bit we, logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      chk(ready === 1'b1, "R2 ready before command", 32'(ready), 1);
      req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      // scramble inputs: the latched copies must be unaffected (R3)
      req = 1'b0; req_addr = ~a; req_wdata = ~d; req_we = ~we;
   endtask

   task automatic do_read(logic [AW-1:0] a);
      logic [DW-1:0] expd;
      expd = shadow.exists(int'(a)) ? shadow[int'(a)] : fill(int'(a));
      accept_cmd(1'b0, a, 8'h00);
      for (int k = 0; k < NRD; k++) begin
         chk_pins("R4 read phase pins", 5'b01010);
         chk(mem_addr === a, "R3 read address held", 32'(mem_addr), 32'(a));
         chk(ready === 1'b0, "R2 busy during read", 32'(ready), 0);
         chk(rd_valid === 1'b0, "R5 no early valid", 32'(rd_valid), 0);
         // a request while busy must be ignored (R2)
         req = (k == 1); req_we = 1'b1;
         @(negedge clk);
      end
      req = 1'b0;
      chk(rd_valid === 1'b1, "R5 valid pulse", 32'(rd_valid), 1);
      chk(rd_data === expd, "R5 read data", 32'(rd_data), 32'(expd));
      for (int j = 0; j < NHZ; j++) begin
         chk_pins("R6 release pins", 5'b10110);
         chk(ready === 1'b0, "R6 ready held off", 32'(ready), 0);
         if (j > 0) chk(rd_valid === 1'b0, "R5 pulse one cycle", 32'(rd_valid), 0);
         @(negedge clk);
      end
      chk(ready === 1'b1, "R6 ready after release", 32'(ready), 1);
      chk_pins("R1 standby after read", 5'b10110);
   endtask

   task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
      accept_cmd(1'b1, a, d);
      for (int k = 0; k < NWP; k++) begin
         chk_pins("R7 write pulse pins", {4'b0110, (k > 0)});
         if (k == 0) chk(mem_dq_oe === 1'b0, "R8 no drive in first pulse cycle", 32'(mem_dq_oe), 0);
         if (k > 0) chk(mem_dq_out === d, "R8 write data", 32'(mem_dq_out), 32'(d));
         chk(mem_addr === a, "R3 write address held", 32'(mem_addr), 32'(a));
         chk(rd_valid === 1'b0, "R9 no valid in write", 32'(rd_valid), 0);
         req = (k == 1); req_we = 1'b0;
         @(negedge clk);
      end
      req = 1'b0;
      for (int j = 0; j < NWR; j++) begin
         chk_pins("R9 write recovery pins", {4'b1011, (j == 0)});
         chk(ready === 1'b0, "R9 busy in recovery", 32'(ready), 0);
         chk(rd_valid === 1'b0, "R9 no valid in recovery", 32'(rd_valid), 0);
         @(negedge clk);
      end
      chk(ready === 1'b1, "R9 ready after write", 32'(ready), 1);
      chk_pins("R1 standby after write", 5'b10110);
      shadow[int'(a)] = d;
   endtask

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected<50000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      chk_pins("R1 pins in reset", 5'b10110);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk_pins("R1 idle standby", 5'b10110);
         chk(ready === 1'b1, "R2 ready when idle", 32'(ready), 1);
         chk(rd_valid === 1'b0, "R5 no valid when idle", 32'(rd_valid), 0);
      end
      do_read(17'h00000);
      do_read(17'h1FFFF);
      do_write(17'h00000, 8'h00);
      do_write(17'h1FFFF, 8'hFF);
      do_write(17'h0AAAA, 8'h5A);
      do_write(17'h15555, 8'hA5);
      do_read(17'h0AAAA);
      do_read(17'h15555);
      do_read(17'h00000);
      do_read(17'h1FFFF);
      do_write(17'h0AAAA, 8'hC3);
      do_read(17'h0AAAA);
      for (int i = 0; i < 8; i++) begin
         do_write(17'(i * 4099), 8'(i * 37 + 1));
         do_read(17'(i * 4099));
      end
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk_pins("R1 final standby", 5'b10110);
      end
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule